// File: doc/BRIEF.md
# Dual-Lane Serial Result Port for an Eight-Channel Converter

This block is the device-side read port of an eight-channel, 14-bit converter. When the converter's busy signal drops, a fresh set of eight results is taken from a parallel bus. A host then reads these results over a serial link made of an active-low chip select, a serial clock and two data lanes. Each lane has its own output-enable, so a pad ring can model a three-state pin. Lane A walks the channels in ascending order. Lane B walks the same results half a rotation later. A host can therefore fetch all eight results in half the clocks with both lanes, or in the full count with one lane.

A first-data flag, also with an output-enable, marks the frame in which channel 1 is about to leave on lane A. Chip select and serial clock are asynchronous host signals. They are resynchronized into the system clock, and their edges are detected there. The serial clock must therefore run well below the system clock. Busy is synchronous to the system clock. Reads are allowed at any time, including while a conversion is in progress.

Top module: `adc_serial_port`

## Requirements
- R1: While chip select is high, `dout_a_oe`, `dout_b_oe` and `first_flag_oe` are all low, and they return low after chip select rises.
- R2: A falling chip select raises all three output-enables and, with no serial clock edge yet, presents the MSB (bit 13) of the current result on each lane.
- R3: Each rising serial clock edge inside a frame advances one bit, MSB first. After 14 rising edges the lane moves to bit 13 of the next channel.
- R4: Channel k (1 to 8) is taken from `result_data[(k-1)*14 +: 14]`. Lane A emits channels 1,2,...,8. Lane B emits 5,6,7,8,1,2,3,4.
- R5: `first_flag` goes high at a chip select fall exactly when lane A is positioned at bit 13 of channel 1.
- R6: With the serial clock idle high, `first_flag` is still high after the 13th falling serial clock edge of the frame. It is low after the 14th.
- R7: When lane B is positioned at channel 1 (lane A at channel 5), a chip select fall leaves `first_flag` low.
- R8: Results are captured only on a falling edge of busy. Changes on `result_data` without such an edge, and a busy level held high during a read, do not alter the data read out.
- R9: The read position carries across chip select frames, and it returns to channel 1, bit 13, whenever new results are applied.
- R10: A busy falling edge during an active frame does not disturb that frame. The captured results are applied when chip select next rises.
- R11: After channel 8 has been shifted out on lane A, further serial clocks continue with channel 1 again (lane B correspondingly with channel 5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Conversion in progress; falling edge captures results |
| result_data | input | 112 | Eight 14-bit results, channel 1 in the low bits |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous, idle high |
| dout_a | output | 1 | Lane A serial data |
| dout_a_oe | output | 1 | Lane A drive enable |
| dout_b | output | 1 | Lane B serial data |
| dout_b_oe | output | 1 | Lane B drive enable |
| first_flag | output | 1 | High while channel 1 leads lane A in the frame |
| first_flag_oe | output | 1 | Drive enable for the flag |

## Verification
The bench reads every channel through both lanes. It uses both one long frame and one frame per result, which exposes a swapped lane rotation or a read position that resets at each chip select. It counts falling edges to pin the flag's drop between the 13th and 14th edges, where an off-by-one counter would clear early or hold the flag too long. It sends a busy edge into the middle of a frame and checks the bits that follow. A design that applies results immediately would corrupt the running frame, and one that drops deferred results would serve stale data in the next frame. It also reads past channel 8 to catch a pointer that saturates instead of wrapping. Finally, it checks that the flag stays low when channel 1 sits on lane B, which catches a flag decoded from the wrong lane.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    // Framing state of the serial port.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_FRAME = 1'b1
    } frame_phase_e;

    // Number of data lanes; lane l starts l*NUM_CH/SP_LANES channels ahead.
    localparam int unsigned SP_LANES = 2;

endpackage

// File: rtl/adc_sp_sync.sv
// Resynchronizes an asynchronous host pin and flags its edges.
module adc_sp_sync #(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.chain <= {STAGES{IDLE_VAL}};
            s_q.prev  <= IDLE_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise = ~s_q.prev &  s_q.chain[STAGES-1];
    assign fall =  s_q.prev & ~s_q.chain[STAGES-1];

endmodule

// File: rtl/adc_sp_bank.sv
// Holding register filled on a busy fall, output bank filled on commit.
module adc_sp_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned RES_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic                    commit,
    input  logic [NUM_CH*RES_W-1:0] result_data,
    output logic [NUM_CH*RES_W-1:0] bank
);

    localparam int unsigned BANK_W = NUM_CH * RES_W;

    typedef struct packed {
        logic [BANK_W-1:0] hold;
        logic [BANK_W-1:0] out;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (commit) begin
            b_d.out = b_q.hold;
        end
        if (capture) begin
            b_d.hold = result_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign bank = b_q.out;

endmodule

// File: rtl/adc_sp_lane_sel.sv
// Picks the current bit of one lane, rotated by a fixed channel offset.
module adc_sp_lane_sel #(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned RES_W     = 14,
    parameter int unsigned CH_OFFSET = 0,
    localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned BIT_W    = $clog2(RES_W)
) (
    input  logic [NUM_CH*RES_W-1:0] bank,
    input  logic [CH_W-1:0]         ch,
    input  logic [BIT_W-1:0]        bitc,
    output logic                    dout
);

    logic [CH_W:0]      sum;
    logic [CH_W-1:0]    idx;
    logic [RES_W-1:0]   word;

    always_comb begin
        sum = {1'b0, ch} + (CH_W+1)'(CH_OFFSET);
        if (sum >= (CH_W+1)'(NUM_CH)) begin
            sum = sum - (CH_W+1)'(NUM_CH);
        end
        idx  = sum[CH_W-1:0];
        word = bank[int'(idx)*RES_W +: RES_W];
        dout = word[BIT_W'(RES_W-1) - bitc];
    end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned RES_W       = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy,
    input  logic [NUM_CH*RES_W-1:0] result_data,
    input  logic                    cs_n,
    input  logic                    sclk,
    output logic                    dout_a,
    output logic                    dout_a_oe,
    output logic                    dout_b,
    output logic                    dout_b_oe,
    output logic                    first_flag,
    output logic                    first_flag_oe
);

    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned BIT_W  = $clog2(RES_W);
    localparam int unsigned BANK_W = NUM_CH * RES_W;
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(RES_W - 1);

    typedef struct packed {
        frame_phase_e    phase;
        logic            flag;
        logic            pend;
        logic            busy_prev;
        logic [CH_W-1:0] ch;
        logic [BIT_W-1:0] bitc;
    } ctl_t;

    ctl_t st_d, st_q;

    logic cs_rise, cs_fall, sclk_rise, sclk_fall;
    logic capture, commit;
    logic [BANK_W-1:0]   bank_flat;
    logic [SP_LANES-1:0] lane_bit;

    adc_sp_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n),
        .rise(cs_rise), .fall(cs_fall)
    );

    adc_sp_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sclk),
        .rise(sclk_rise), .fall(sclk_fall)
    );

    assign capture = st_q.busy_prev & ~busy;
    assign commit  = st_q.pend & (st_q.phase == PH_IDLE);

    adc_sp_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .capture(capture), .commit(commit),
        .result_data(result_data), .bank(bank_flat)
    );

    for (genvar l = 0; l < SP_LANES; l++) begin : g_lane
        adc_sp_lane_sel #(
            .NUM_CH(NUM_CH), .RES_W(RES_W),
            .CH_OFFSET(l * NUM_CH / SP_LANES)
        ) u_sel (
            .bank(bank_flat), .ch(st_q.ch), .bitc(st_q.bitc),
            .dout(lane_bit[l])
        );
    end

    always_comb begin
        st_d           = st_q;
        st_d.busy_prev = busy;

        if (capture) begin
            st_d.pend = 1'b1;
        end else if (commit) begin
            st_d.pend = 1'b0;
        end

        // New results restart the walk at channel 1, MSB.
        if (commit) begin
            st_d.ch   = '0;
            st_d.bitc = '0;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (cs_fall) begin
                    st_d.phase = PH_FRAME;
                    st_d.flag  = (st_d.ch == '0) && (st_d.bitc == '0);
                end
            end
            PH_FRAME: begin
                if (cs_rise) begin
                    st_d.phase = PH_IDLE;
                    st_d.flag  = 1'b0;
                end else begin
                    if (sclk_fall && (st_q.ch == '0) && (st_q.bitc == BIT_LAST)) begin
                        st_d.flag = 1'b0;
                    end
                    if (sclk_rise) begin
                        if (st_q.bitc == BIT_LAST) begin
                            st_d.bitc = '0;
                            st_d.ch   = (st_q.ch == CH_LAST) ? '0 : st_q.ch + 1'b1;
                        end else begin
                            st_d.bitc = st_q.bitc + 1'b1;
                        end
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase     <= PH_IDLE;
            st_q.flag      <= 1'b0;
            st_q.pend      <= 1'b0;
            st_q.busy_prev <= 1'b0;
            st_q.ch        <= '0;
            st_q.bitc      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_a        = lane_bit[0];
    assign dout_b        = lane_bit[1];
    assign dout_a_oe     = (st_q.phase == PH_FRAME);
    assign dout_b_oe     = (st_q.phase == PH_FRAME);
    assign first_flag    = st_q.flag;
    assign first_flag_oe = (st_q.phase == PH_FRAME);

endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker #(
    parameter int unsigned BANK_W = 112
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              dout_a_oe,
    input logic              first_flag,
    input logic [BANK_W-1:0] bank_flat
);

    // R2: drivers only turn on after chip select has been low for a while
    a_r2_oe_after_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_a_oe) |-> (!$past(cs_n, 1) && !$past(cs_n, 2)));

    // R1: drivers only turn off after chip select has been high
    a_r1_oe_off_after_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_a_oe) |-> ($past(cs_n, 1) && $past(cs_n, 2)));

    // R5: the flag can only rise at the start of a frame
    a_r5_flag_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(first_flag) |-> $rose(dout_a_oe));

    // R10: read-out results never change while a frame was running
    a_r10_bank_frozen_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_flat != $past(bank_flat)) |-> !$past(dout_a_oe));

endmodule

bind adc_serial_port adc_sp_checker #(.BANK_W(NUM_CH * RES_W)) i_adc_sp_checker (
    .clk(clk),
    .rst_n(rst_n),
    .cs_n(cs_n),
    .dout_a_oe(dout_a_oe),
    .first_flag(first_flag),
    .bank_flat(bank_flat)
);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;

    localparam int NUM_CH = 8;
    localparam int RES_W  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic [NUM_CH*RES_W-1:0] result_data = '0;
    logic dout_a, dout_a_oe, dout_b, dout_b_oe, first_flag, first_flag_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_serial_port #(.NUM_CH(NUM_CH), .RES_W(RES_W), .SYNC_STAGES(2)) i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .busy(busy), .result_data(result_data),
        .cs_n(cs_n), .sclk(sclk),
        .dout_a(dout_a), .dout_a_oe(dout_a_oe),
        .dout_b(dout_b), .dout_b_oe(dout_b_oe),
        .first_flag(first_flag), .first_flag_oe(first_flag_oe)
    );

    // Row: [15] read lane B, [14] one frame per result, [13:0] seed
    localparam logic [15:0] VEC [4] = '{16'h0A5C, 16'h4F0F, 16'h8123, 16'hC3E7};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] ev(input logic [13:0] seed, input int k);
        return (seed ^ 14'(k * 32'h1111)) + 14'(k);
    endfunction

    function automatic logic [NUM_CH*RES_W-1:0] pack(input logic [13:0] seed);
        logic [NUM_CH*RES_W-1:0] r;
        for (int k = 0; k < NUM_CH; k++) r[k*RES_W +: RES_W] = ev(seed, k);
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [13:0] seed);
        result_data = pack(seed);
        busy = 1'b1;
        tick(3);
        busy = 1'b0;
        tick(4);
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        tick(6);
    endtask

    task automatic frame_end();
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic read_word(input logic lane, output logic [13:0] w,
                             output logic f13, output logic f14);
        f13 = 1'b0;
        f14 = 1'b0;
        for (int b = 0; b < RES_W; b++) begin
            sclk = 1'b0;
            tick(5);
            w[13-b] = lane ? dout_b : dout_a;
            if (b == 12) f13 = first_flag;
            if (b == 13) f14 = first_flag;
            sclk = 1'b1;
            tick(5);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [13:0] w;
        logic f13, f14;
        logic lane, per;
        logic [13:0] seed;

        tick(5);
        chk("R1 reset outputs released", {dout_a_oe, dout_b_oe, first_flag_oe}, 3'b000);
        rst_n = 1'b1;
        tick(3);

        for (int r = 0; r < 4; r++) begin
            lane = VEC[r][15];
            per  = VEC[r][14];
            seed = VEC[r][13:0];
            load(seed);
            for (int i = 0; i < NUM_CH; i++) begin
                if (i == 0 || per) frame_start();
                if (i == 0) begin
                    chk("R2 enables on at frame start", {dout_a_oe, dout_b_oe, first_flag_oe}, 3'b111);
                    chk("R2 MSB before any clock", lane ? dout_b : dout_a,
                        ev(seed, lane ? 4 : 0) >> 13);
                    chk("R5 flag raised for channel 1", first_flag, 1'b1);
                end
                read_word(lane, w, f13, f14);
                chk("R3 R4 R9 lane word", w, ev(seed, lane ? (i + 4) % NUM_CH : i));
                if (i == 0) begin
                    chk("R6 flag held after 13th fall", f13, 1'b1);
                    chk("R6 flag dropped after 14th fall", f14, 1'b0);
                end
                if (per || i == NUM_CH - 1) frame_end();
            end
            chk("R1 enables off after frame", {dout_a_oe, dout_b_oe, first_flag_oe}, 3'b000);
        end

        // R11: ninth word wraps to channel 1 on lane A
        load(14'h1357);
        frame_start();
        for (int i = 0; i < NUM_CH; i++) read_word(1'b0, w, f13, f14);
        read_word(1'b0, w, f13, f14);
        chk("R11 wrap to channel 1", w, ev(14'h1357, 0));
        frame_end();

        // R7: channel 1 on lane B does not raise the flag
        load(14'h2468);
        frame_start();
        for (int i = 0; i < 4; i++) read_word(1'b0, w, f13, f14);
        frame_end();
        frame_start();
        chk("R7 flag low with channel 1 on lane B", first_flag, 1'b0);
        read_word(1'b1, w, f13, f14);
        chk("R7 lane B carries channel 1", w, ev(14'h2468, 0));
        frame_end();

        // R9: new results reset the position
        load(14'h0F1E);
        frame_start();
        for (int i = 0; i < 3; i++) read_word(1'b0, w, f13, f14);
        frame_end();
        load(14'h3C2D);
        frame_start();
        chk("R9 flag after reload", first_flag, 1'b1);
        read_word(1'b0, w, f13, f14);
        chk("R9 position reset on reload", w, ev(14'h3C2D, 0));
        frame_end();

        // R8: no capture without a busy fall; read while busy is high
        load(14'h1A1A);
        busy = 1'b1;
        tick(2);
        result_data = pack(14'h2B2B);
        tick(3);
        frame_start();
        read_word(1'b0, w, f13, f14);
        chk("R8 read during busy keeps old data", w, ev(14'h1A1A, 0));
        frame_end();
        result_data = pack(14'h3C3C);
        tick(2);
        busy = 1'b0;
        tick(4);
        result_data = pack(14'h0D0D);
        tick(4);
        frame_start();
        read_word(1'b0, w, f13, f14);
        chk("R8 data taken at busy fall only", w, ev(14'h3C3C, 0));
        frame_end();

        // R10: busy fall inside a frame is deferred
        load(14'h0777);
        frame_start();
        for (int i = 0; i < 2; i++) read_word(1'b0, w, f13, f14);
        result_data = pack(14'h1888);
        busy = 1'b1;
        tick(3);
        busy = 1'b0;
        tick(4);
        read_word(1'b0, w, f13, f14);
        chk("R10 running frame keeps old data", w, ev(14'h0777, 2));
        frame_end();
        frame_start();
        chk("R10 deferred results restart at channel 1", first_flag, 1'b1);
        read_word(1'b0, w, f13, f14);
        chk("R10 deferred results applied", w, ev(14'h1888, 0));
        frame_end();
        chk("R1 enables off at end", {dout_a_oe, dout_b_oe, first_flag_oe}, 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule